// File: doc/BRIEF.md
# SATA DMA Command Responder

This block is the command engine on the device side of a small SATA target whose storage is an internal sector RAM. The transport layer hands it the received frames one dword at a time. The type of each frame sits in the low byte of its first dword. The block acts on two commands carried in a host-to-device register frame: the 48-bit-addressed DMA read and the 48-bit-addressed DMA write. It also acts on the data frames that carry write payload. It answers with its own frames: DMA Activate, Data and device-to-host register frames. Link framing, scrambling and CRC belong to the neighbouring layers.

A read is returned as a series of Data frames. Each one holds at most `MAX_PAYLOAD_DW` payload dwords, and a register frame closes the series. A write is paced by the block. It sends one DMA Activate for each data frame it wants, and it sends a register frame once the addressed range is full. The receive side stalls while a response is going out, so the block handles one frame at a time.

Top module: `sata_dma_responder`

## Requirements
- R1: After reset the block accepts input (`rx_ready`=1) and drives no output (`tx_valid`=0).
- R2: Input frames are ignored and give no output if their type byte (dword 0 bits [7:0]) is not 0x27 or 0x46. A 0x27 frame is also ignored if its command byte (dword 0 bits [23:16]) is neither 0x25 (read) nor 0x35 (write).
- R3: An accepted write command is answered with a one-dword DMA Activate frame, 0x00000039, which has `tx_last` set.
- R4: Each payload dword of a data frame (type 0x46, dwords after the header) received while a write is open is stored at the current write position, which then advances by one dword. Dwords beyond the end of the commanded range are dropped.
- R5: At the end of each data frame received while a write is open, the block sends a register frame with status OK if the write position has reached the end of the range. Otherwise it sends another DMA Activate. The OK frame closes the write.
- R6: A read is answered with Data frames. Each has header 0x00000046 followed by min(remaining dwords, `MAX_PAYLOAD_DW`) dwords taken from RAM in ascending address order, and the last of them carries `tx_last`.
- R7: The last read Data frame is followed by one 5-dword register frame. Dword 0 is 0x00504034 (type 0x34, flags 0x40, status 0x50, error 0x00) and dwords 1 to 4 are zero.
- R8: A read or write command with count 0, or with start+count greater than `RAM_SECTORS`, is answered only with a register frame whose dword 0 is 0x04514034 (status 0x51, error 0x04). It closes any open write.
- R9: While `tx_valid`=1 and `tx_ready`=0, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R10: `rx_ready` is low in every cycle in which `tx_valid` is high.
- R11: A data frame received when no write is open changes no RAM content and produces no output.
- R12: The start sector is formed from the 48-bit LBA, with bits [23:0] taken from dword 1 bits [23:0] and bits [47:24] taken from dword 2 bits [23:0]. The count is taken from dword 3 bits [15:0]. The RAM dword address is sector × `SECTOR_DW` plus the offset within the sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received frame dword valid |
| rx_data | input | 32 | Received frame dword |
| rx_last | input | 1 | Marks the last dword of a received frame |
| rx_ready | output | 1 | Block accepts a received dword |
| tx_valid | output | 1 | Response dword valid |
| tx_data | output | 32 | Response dword |
| tx_last | output | 1 | Marks the last dword of a response frame |
| tx_ready | input | 1 | Downstream accepts the response dword |

## Verification
A corrupted write position or range end appears at the ports at the end of the same data frame: a DMA Activate comes out where an OK register frame was due, or the reverse. Misplaced payload appears on the next read of that range, in the first Data frame. A wrong remaining count shows up as a Data frame of the wrong length or a register frame sent too early. A lost write-open flag turns a paced write into silence or produces a spurious response, visible within a few cycles of the frame's last dword.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam logic [7:0] T_H2D  = 8'h27;
  localparam logic [7:0] T_D2H  = 8'h34;
  localparam logic [7:0] T_ACT  = 8'h39;
  localparam logic [7:0] T_DATA = 8'h46;
  localparam logic [7:0] CMD_RD = 8'h25;
  localparam logic [7:0] CMD_WR = 8'h35;
  localparam logic [7:0] ST_OK  = 8'h50;
  localparam logic [7:0] ST_ERR = 8'h51;
  localparam logic [7:0] ER_ABRT = 8'h04;
  localparam logic [7:0] FL_IRQ = 8'h40;
  localparam int D2H_DW = 5;

  typedef enum logic [2:0] {S_RX, S_CMD, S_ACT, S_DHDR, S_DPAY, S_D2H} state_e;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [47:0] lba;
    logic [15:0] cnt;
  } cmd_t;
endpackage

// File: rtl/sdr_ram.sv
module sdr_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sdr_frame_rx.sv
module sdr_frame_rx import sdr_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [31:0] data,
  input  logic        last,
  output logic        first,
  output logic [7:0]  ftype,
  output cmd_t        cmd
);
  logic [2:0] idx_q, idx_d;
  logic [7:0] type_q, type_d;
  cmd_t       cmd_q, cmd_d;
  logic       unused_bits;

  assign unused_bits = ^{data[31:24], data[15:8]};
  assign first = (idx_q == 3'd0);
  assign ftype = first ? data[7:0] : type_q;
  assign cmd   = cmd_q;

  always_comb begin
    idx_d  = idx_q;
    type_d = type_q;
    cmd_d  = cmd_q;
    if (take) begin
      if (last)               idx_d = 3'd0;
      else if (idx_q != 3'd7) idx_d = idx_q + 3'd1;
      if (first) type_d = data[7:0];
      case (idx_q)
        3'd0: cmd_d.cmd        = data[23:16];
        3'd1: cmd_d.lba[23:0]  = data[23:0];
        3'd2: cmd_d.lba[47:24] = data[23:0];
        3'd3: cmd_d.cnt        = data[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 3'd0;
      type_q <= 8'h00;
      cmd_q  <= '0;
    end else if (take) begin
      idx_q  <= idx_d;
      type_q <= type_d;
      cmd_q  <= cmd_d;
    end
  end
endmodule

// File: rtl/sdr_range.sv
module sdr_range #(
  parameter int SECTORS   = 8,
  parameter int SECTOR_DW = 128,
  parameter int AW1       = 11
) (
  input  logic [47:0]    lba,
  input  logic [15:0]    cnt,
  output logic           ok,
  output logic [AW1-1:0] start_dw,
  output logic [AW1-1:0] end_dw
);
  logic [48:0] stop;

  always_comb begin
    stop     = {1'b0, lba} + {33'd0, cnt};
    ok       = (cnt != 16'd0) && (stop <= 49'(SECTORS));
    start_dw = AW1'(lba) * AW1'(SECTOR_DW);
    end_dw   = AW1'(stop) * AW1'(SECTOR_DW);
  end
endmodule

// File: rtl/sata_dma_responder.sv
module sata_dma_responder import sdr_pkg::*; #(
  parameter int SECTOR_DW      = 128,
  parameter int MAX_PAYLOAD_DW = 2048,
  parameter int RAM_SECTORS    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [31:0] rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int DEPTH = RAM_SECTORS * SECTOR_DW;
  localparam int AW    = $clog2(DEPTH);
  localparam int AW1   = AW + 1;
  localparam int CW    = $clog2(MAX_PAYLOAD_DW + 1);

  state_e         state_q, state_d;
  logic           wact_q, wact_d, err_q, err_d;
  logic [AW1-1:0] wptr_q, wptr_d, wend_q, wend_d;
  logic [AW1-1:0] rptr_q, rptr_d, rend_q, rend_d;
  logic [CW-1:0]  left_q, left_d;
  logic [2:0]     didx_q, didx_d;

  logic           take, first, ram_we, rng_ok, fire;
  logic [7:0]     ftype;
  cmd_t           cmd;
  logic [AW1-1:0] start_dw, end_dw, rem;
  logic [31:0]    rem32, rdata;

  assign rx_ready = (state_q == S_RX);
  assign take     = rx_valid && rx_ready;
  assign ram_we   = take && !first && (ftype == T_DATA) && wact_q && (wptr_q < wend_q);
  assign fire     = tx_valid && tx_ready;
  assign rem      = rend_q - rptr_q;
  assign rem32    = 32'(rem);

  sdr_frame_rx u_frame (
    .clk(clk), .rst_n(rst_n), .take(take), .data(rx_data), .last(rx_last),
    .first(first), .ftype(ftype), .cmd(cmd)
  );

  sdr_range #(.SECTORS(RAM_SECTORS), .SECTOR_DW(SECTOR_DW), .AW1(AW1)) u_range (
    .lba(cmd.lba), .cnt(cmd.cnt), .ok(rng_ok), .start_dw(start_dw), .end_dw(end_dw)
  );

  sdr_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wptr_q[AW-1:0]), .wdata(rx_data),
    .raddr(rptr_q[AW-1:0]), .rdata(rdata)
  );

  // output mux
  always_comb begin
    tx_valid = 1'b0;
    tx_data  = 32'h0;
    tx_last  = 1'b0;
    case (state_q)
      S_ACT:  begin tx_valid = 1'b1; tx_data = {24'h0, T_ACT}; tx_last = 1'b1; end
      S_DHDR: begin tx_valid = 1'b1; tx_data = {24'h0, T_DATA}; end
      S_DPAY: begin tx_valid = 1'b1; tx_data = rdata; tx_last = (left_q == CW'(1)); end
      S_D2H: begin
        tx_valid = 1'b1;
        tx_last  = (didx_q == 3'(D2H_DW - 1));
        if (didx_q == 3'd0)
          tx_data = {err_q ? ER_ABRT : 8'h00, err_q ? ST_ERR : ST_OK, FL_IRQ, T_D2H};
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    wact_d  = wact_q;
    err_d   = err_q;
    wptr_d  = wptr_q;
    wend_d  = wend_q;
    rptr_d  = rptr_q;
    rend_d  = rend_q;
    left_d  = left_q;
    didx_d  = didx_q;
    case (state_q)
      S_RX: begin
        if (ram_we) wptr_d = wptr_q + 1'b1;
        if (take && rx_last) begin
          if (ftype == T_H2D) begin
            state_d = S_CMD;
          end else if (ftype == T_DATA && wact_q) begin
            if (wptr_d >= wend_q) begin
              wact_d  = 1'b0;
              err_d   = 1'b0;
              state_d = S_D2H;
            end else begin
              state_d = S_ACT;
            end
          end
        end
      end
      S_CMD: begin
        state_d = S_RX;
        if (cmd.cmd == CMD_RD || cmd.cmd == CMD_WR) begin
          wact_d = 1'b0;
          if (!rng_ok) begin
            err_d   = 1'b1;
            state_d = S_D2H;
          end else if (cmd.cmd == CMD_RD) begin
            rptr_d  = start_dw;
            rend_d  = end_dw;
            state_d = S_DHDR;
          end else begin
            wptr_d  = start_dw;
            wend_d  = end_dw;
            wact_d  = 1'b1;
            state_d = S_ACT;
          end
        end
      end
      S_ACT:  if (fire) state_d = S_RX;
      S_DHDR: if (fire) begin
        left_d  = (rem32 > 32'(MAX_PAYLOAD_DW)) ? CW'(MAX_PAYLOAD_DW) : CW'(rem32);
        state_d = S_DPAY;
      end
      S_DPAY: if (fire) begin
        rptr_d = rptr_q + 1'b1;
        left_d = left_q - 1'b1;
        if (tx_last) begin
          if (rptr_d == rend_q) begin
            err_d   = 1'b0;
            state_d = S_D2H;
          end else begin
            state_d = S_DHDR;
          end
        end
      end
      S_D2H: if (fire) begin
        didx_d = didx_q + 3'd1;
        if (tx_last) begin
          didx_d  = 3'd0;
          state_d = S_RX;
        end
      end
      default: state_d = S_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RX;
      wact_q  <= 1'b0;
      err_q   <= 1'b0;
      wptr_q  <= '0;
      wend_q  <= '0;
      rptr_q  <= '0;
      rend_q  <= '0;
      left_q  <= '0;
      didx_q  <= 3'd0;
    end else begin
      state_q <= state_d;
      wact_q  <= wact_d;
      err_q   <= err_d;
      wptr_q  <= wptr_d;
      wend_q  <= wend_d;
      rptr_q  <= rptr_d;
      rend_q  <= rend_d;
      left_q  <= left_d;
      didx_q  <= didx_d;
    end
  end
endmodule

// File: rtl/sdr_checker.sv
module sdr_checker #(
  parameter int MAX_PAYLOAD_DW = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic [31:0] tx_data,
  input logic        tx_last,
  input logic        tx_ready
);
  logic        sof_q, d2h_q;
  logic [31:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_q <= 1'b1;
      d2h_q <= 1'b0;
      len_q <= 32'd0;
    end else if (tx_valid && tx_ready) begin
      sof_q <= tx_last;
      len_q <= tx_last ? 32'd0 : len_q + 32'd1;
      if (sof_q) d2h_q <= (tx_data[7:0] == 8'h34);
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_half_duplex_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));

  p_act_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && sof_q && tx_data[7:0] == 8'h39 |-> tx_last && tx_data[31:8] == 24'h0);

  p_frame_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && sof_q |-> tx_data[7:0] == 8'h34 || tx_data[7:0] == 8'h39 || tx_data[7:0] == 8'h46);

  p_chunk_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> len_q <= 32'(MAX_PAYLOAD_DW));

  p_d2h_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_last && !sof_q && d2h_q |-> len_q == 32'd4);
endmodule

bind sata_dma_responder sdr_checker #(.MAX_PAYLOAD_DW(MAX_PAYLOAD_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/sata_dma_responder_test.sv
module sata_dma_responder_test;
  localparam int SD = 4;
  localparam int MX = 8;
  localparam int NS = 16;
  localparam int DEPTH = SD * NS;

  logic        clk, rst_n;
  logic        rx_valid, rx_last, rx_ready;
  logic [31:0] rx_data;
  logic        tx_valid, tx_last, tx_ready;
  logic [31:0] tx_data;

  int errs = 0;
  int checks = 0;

  logic [31:0] mdl [DEPTH];
  logic [31:0] got [16];
  logic [31:0] exf [16];
  int glen, elen;
  bit b_wact;
  int b_ptr, b_end;

  sata_dma_responder #(.SECTOR_DW(SD), .MAX_PAYLOAD_DW(MX), .RAM_SECTORS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run hung (actual=running expected=finished)");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic push(input logic [31:0] d, input logic l);
    bit acc;
    rx_valid = 1'b1; rx_data = d; rx_last = l;
    do begin
      acc = rx_ready;
      @(negedge clk);
    end while (!acc);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic get_frame();
    bit done = 0;
    glen = 0;
    while (!done) begin
      tx_ready = ($urandom % 4) != 0;
      if (tx_valid && tx_ready) begin
        if (glen < 16) got[glen] = tx_data;
        glen++;
        done = tx_last;
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
  endtask

  task automatic compare(input string req);
    int bad = -1;
    checks++;
    if (glen != elen) begin
      errs++;
      $display("FAIL %s: frame length actual=%0d expected=%0d", req, glen, elen);
      return;
    end
    for (int i = 0; i < elen; i++) if (bad < 0 && got[i] !== exf[i]) bad = i;
    if (bad >= 0) begin
      errs++;
      $display("FAIL %s: dword %0d actual=%08h expected=%08h", req, bad, got[bad], exf[bad]);
    end
  endtask

  function automatic void exp_d2h(input bit err);
    elen = 5;
    exf[0] = err ? 32'h0451_4034 : 32'h0050_4034;
    for (int i = 1; i < 5; i++) exf[i] = 32'h0;
  endfunction

  function automatic void exp_act();
    elen = 1;
    exf[0] = 32'h0000_0039;
  endfunction

  function automatic bit in_range(input logic [47:0] lba, input int cnt);
    return cnt != 0 && lba <= 48'(NS) && int'(lba) + cnt <= NS;
  endfunction

  task automatic quiet(input string req);
    bit seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (tx_valid) seen = 1;
    end
    checks++;
    if (seen || !rx_ready) begin
      errs++;
      $display("FAIL %s: unexpected output/stall actual=%0b/%0b expected=0/1", req, seen, rx_ready);
    end
  endtask

  // R12: field placement of the register frame
  task automatic send_cmd(input logic [7:0] cmd, input logic [47:0] lba, input int cnt);
    push({8'h00, cmd, 8'h80, 8'h27}, 1'b0);
    push({8'h40, lba[23:0]}, 1'b0);
    push({8'h00, lba[47:24]}, 1'b0);
    push({16'h0, 16'(cnt)}, 1'b0);
    push(32'h0, 1'b1);
    if (cmd != 8'h25 && cmd != 8'h35) begin
      quiet("R2 other command");
      return;
    end
    b_wact = 0;
    if (!in_range(lba, cnt)) begin
      get_frame(); exp_d2h(1); compare("R8 range error");
      return;
    end
    if (cmd == 8'h35) begin
      b_wact = 1; b_ptr = int'(lba) * SD; b_end = b_ptr + cnt * SD;
      get_frame(); exp_act(); compare("R3 write activate");
    end else begin
      int p = int'(lba) * SD;
      int e = p + cnt * SD;
      while (p < e) begin
        int n = (e - p > MX) ? MX : e - p;
        get_frame();
        elen = n + 1;
        exf[0] = 32'h46;
        for (int i = 0; i < n; i++) exf[i+1] = mdl[p+i];
        compare("R6 R12 read data");
        p += n;
      end
      get_frame(); exp_d2h(0); compare("R7 read done");
    end
  endtask

  task automatic send_data(input int n);
    push(32'h0000_0046, n == 0);
    for (int i = 0; i < n; i++) begin
      logic [31:0] v = $urandom;
      push(v, i == n - 1);
      if (b_wact && b_ptr < b_end) begin
        mdl[b_ptr] = v;
        b_ptr++;
      end
    end
    if (!b_wact) begin
      quiet("R11 stray data");
      return;
    end
    get_frame();
    if (b_ptr >= b_end) begin
      b_wact = 0; exp_d2h(0); compare("R5 R4 write done");
    end else begin
      exp_act(); compare("R5 write continue");
    end
  endtask

  task automatic write_full(input logic [47:0] lba, input int cnt);
    send_cmd(8'h35, lba, cnt);
    while (b_wact) send_data((b_end - b_ptr > MX) ? MX : b_end - b_ptr);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; tx_ready = 1'b0;
    b_wact = 0; b_ptr = 0; b_end = 0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rx_ready !== 1'b1 || tx_valid !== 1'b0) begin
      errs++;
      $display("FAIL R1 reset: rx_ready/tx_valid actual=%0b/%0b expected=1/0", rx_ready, tx_valid);
    end

    write_full(48'd0, NS);                 // fill whole RAM, R3 R4 R5
    send_cmd(8'h25, 48'd0, NS);            // R6 chunked read

    // R2: unknown type and non-DMA command
    push(32'h0000_005A, 1'b0); push(32'h1234_5678, 1'b0); push(32'h0, 1'b1);
    quiet("R2 unknown type");
    send_cmd(8'hEC, 48'd2, 1);

    // R11: data frame without open write, then readback
    send_data(4);
    send_cmd(8'h25, 48'd0, 2);

    // R4: partial-sector frames
    send_cmd(8'h35, 48'd5, 2);
    send_data(6);
    send_data(2);
    send_cmd(8'h25, 48'd5, 2);

    // R4: overrun dropped
    send_cmd(8'h35, 48'd3, 1);
    send_data(8);
    send_cmd(8'h25, 48'd3, 2);

    // R8 / R12: error cases
    send_cmd(8'h25, 48'd15, 2);
    send_cmd(8'h35, 48'd14, 3);
    send_data(4);                          // write closed by error, R11
    send_cmd(8'h25, 48'd4, 0);
    send_cmd(8'h25, 48'h0000_4000_0002, 1);
    send_cmd(8'h25, 48'd15, 1);            // last sector boundary

    // constrained random
    for (int k = 0; k < 30; k++) begin
      logic [47:0] l = 48'($urandom % (NS + 2));
      int c = $urandom % 7;
      if ($urandom % 2) write_full(l, c);
      else send_cmd(8'h25, l, c);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule